// File: doc/BRIEF.md
# RC4 Keystream Engine with APB Register Access

This peripheral runs the RC4 stream cipher in hardware and is reached through an APB slave port. Software loads a key of 1 to 256 bytes into a key window, writes the key length, and sets a start bit. The engine then sets its 256-entry byte permutation to the identity and runs the key-scheduling pass, reusing the key cyclically whenever it is shorter than 256 bytes. While this runs a busy flag is raised.

Once scheduling is done the engine reports itself ready. Each byte written to the data-in register advances the generator by one step and produces one keystream byte. That byte is XORed with the written byte and placed in the data-out register, and a valid flag is raised. Encryption and decryption are the same operation, so ciphertext fed back in under the same key returns the plaintext.

Register map (byte offsets, the low two address bits ignored): 0x000 control, 0x004 key length, 0x008 status, 0x00C data-in, 0x010 data-out. Key byte n sits at 0x400 + 4*n. All data fields use bits [7:0]. Other addresses read as zero, and writes to them do nothing.

Top module: `rc4p_engine`

## Requirements
- R1: After reset the status register (0x008) reads 0, data-out (0x010) reads 0 and key length (0x004) reads 0.
- R2: The key length register (0x004, bits [7:0]) holds the key length minus one (0 means 1 byte, 255 means 256 bytes) and reads back what was written. A write to it while the busy flag is set is ignored.
- R3: Key byte n is written at address 0x400 + 4*n, bits [7:0]. A key write while the busy flag is set is ignored.
- R4: Writing 1 to bit 0 of control (0x000) while idle starts a schedule, and status bit 0 (busy) is then set for exactly 257 cycles: one cycle to load the identity permutation and 256 scheduling steps. A start write while busy is ignored.
- R5: Scheduling applies j = j + S[i] + K[i mod len] (mod 256) and swaps S[i] with S[j] for i = 0..255, starting from j = 0, so the keystream matches the standard cipher. For example, key "Key" gives EB as the first byte and key "Wiki" gives 60.
- R6: A data-in write (0x00C) while ready and idle steps the generator: i = i+1, j = j+S[i], swap, output S[S[i]+S[j]]. The output XOR the data byte appears at data-out, and status bit 1 (valid) rises three cycles after the accepting clock edge.
- R7: An APB read of data-out clears the valid flag.
- R8: Data-in writes made before any schedule has finished, or while busy, are ignored: valid stays clear and the generator does not advance.
- R9: The generator index wraps from 255 back to 0, and the keystream stays correct past 256 bytes.
- R10: prdata is zero except during a read access phase (psel, penable high and pwrite low). Unmapped addresses read as zero.
- R11: Status bit 2 (ready) is cleared when a schedule starts and is set when busy falls.
- R12: Feeding ciphertext back in under the same key, rescheduled, returns the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and engine clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write transfer, 0 = read transfer |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, zero outside a read access |

## Verification
The assertions assume that the master follows the two-phase transfer: select first, penable only in the following cycle, and address and control held steady throughout. They also assume that each transfer makes a single access. The valid-latency property relies on no further data-in write being taken while a byte is in flight. The bench meets this by polling the valid flag before each new data-in write, and it runs every transfer through one write task and one read task that build the setup and access phases on falling clock edges.

// File: rtl/rc4p_pkg.sv
package rc4p_pkg;

  localparam int BYTE_W  = 8;
  localparam int S_DEPTH = 1 << BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_INIT,
    SQ_KSA,
    SQ_GEN,
    SQ_OUT
  } seq_e;

  // register byte offsets
  localparam int OFF_CTRL   = 'h000;
  localparam int OFF_KEYLEN = 'h004;
  localparam int OFF_STATUS = 'h008;
  localparam int OFF_DIN    = 'h00C;
  localparam int OFF_DOUT   = 'h010;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_VALID = 1;
  localparam int ST_READY = 2;

  // scheduling mix: new j from old j, state entry and key byte
  function automatic byte_t ksa_mix(byte_t j, byte_t s_i, byte_t k_i);
    return byte_t'(j + s_i + k_i);
  endfunction

  // generation mix: new j from old j and state entry
  function automatic byte_t gen_mix(byte_t j, byte_t s_i);
    return byte_t'(j + s_i);
  endfunction

  // index of the entry emitted as keystream
  function automatic byte_t out_index(byte_t a, byte_t b);
    return byte_t'(a + b);
  endfunction

endpackage

// File: rtl/rc4p_apb_slave.sv
module rc4p_apb_slave
  import rc4p_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int KEY_IDX_W = 8
) (
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  input  logic [KEY_IDX_W-1:0] keylen_q,
  input  byte_t                dout_q,
  input  logic                 busy,
  input  logic                 dvalid,
  input  logic                 ready,
  output logic                 start_wr,
  output logic                 keylen_wr,
  output logic                 key_wr,
  output logic [KEY_IDX_W-1:0] key_idx,
  output byte_t                wr_byte,
  output logic                 din_wr,
  output logic                 dout_rd,
  output logic [DATA_W-1:0]    prdata
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(OFF_CTRL   >> 2);
  localparam logic [WORD_W-1:0] W_KEYLEN = WORD_W'(OFF_KEYLEN >> 2);
  localparam logic [WORD_W-1:0] W_STATUS = WORD_W'(OFF_STATUS >> 2);
  localparam logic [WORD_W-1:0] W_DIN    = WORD_W'(OFF_DIN    >> 2);
  localparam logic [WORD_W-1:0] W_DOUT   = WORD_W'(OFF_DOUT   >> 2);

  logic              acc_wr, acc_rd, in_key_win;
  logic [WORD_W-1:0] word;
  logic              unused_bits;

  assign word        = paddr[ADDR_W-1:2];
  assign acc_wr      = psel && penable && pwrite;
  assign acc_rd      = psel && penable && !pwrite;
  assign in_key_win  = (paddr[ADDR_W-1 -: 2] == 2'b01);
  assign key_idx     = paddr[KEY_IDX_W+1:2];
  assign wr_byte     = pwdata[BYTE_W-1:0];
  assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:BYTE_W]};

  assign start_wr  = acc_wr && (word == W_CTRL) && pwdata[0];
  assign keylen_wr = acc_wr && (word == W_KEYLEN);
  assign din_wr    = acc_wr && (word == W_DIN);
  assign key_wr    = acc_wr && in_key_win;
  assign dout_rd   = acc_rd && (word == W_DOUT);

  always_comb begin
    prdata = '0;
    if (acc_rd) begin
      if (word == W_KEYLEN)      prdata = DATA_W'(keylen_q);
      else if (word == W_STATUS) begin
        prdata[ST_BUSY]  = busy;
        prdata[ST_VALID] = dvalid;
        prdata[ST_READY] = ready;
      end
      else if (word == W_DOUT)   prdata = DATA_W'(dout_q);
    end
  end

endmodule

// File: rtl/rc4p_key_store.sv
module rc4p_key_store
  import rc4p_pkg::*;
#(
  parameter int KEY_DEPTH = 256,
  parameter int KI_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock,
  input  logic            len_wr,
  input  logic            key_wr,
  input  logic [KI_W-1:0] wr_idx,
  input  byte_t           wr_byte,
  input  logic [KI_W-1:0] rd_idx,
  output byte_t           rd_byte,
  output logic [KI_W-1:0] lenm1
);

  byte_t           key_q [KEY_DEPTH];
  logic [KI_W-1:0] lenm1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < KEY_DEPTH; n++) key_q[n] <= '0;
      lenm1_q <= '0;
    end else if (!lock) begin
      if (key_wr) key_q[wr_idx] <= wr_byte;
      if (len_wr) lenm1_q <= KI_W'(wr_byte);
    end
  end

  assign rd_byte = key_q[rd_idx];
  assign lenm1   = lenm1_q;

endmodule

// File: rtl/rc4p_sbox_seq.sv
module rc4p_sbox_seq
  import rc4p_pkg::*;
#(
  parameter int KI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            din_req,
  input  byte_t           din_byte,
  input  logic            dout_rd,
  input  byte_t           key_byte,
  input  logic [KI_W-1:0] key_lenm1,
  output logic [KI_W-1:0] key_idx,
  output byte_t           dout,
  output logic            busy,
  output logic            dvalid,
  output logic            ready,
  output logic            start_accept,
  output logic            din_accept,
  output logic            ksa_step,
  output logic            gen_swap,
  output logic            out_load
);

  localparam byte_t LAST_I = byte_t'(S_DEPTH - 1);

  seq_e            state;
  byte_t           s_q [S_DEPTH];
  byte_t           i_q, j_q, t_q, din_q, dout_q;
  logic [KI_W-1:0] kidx_q;
  logic            dvalid_q, ready_q;

  byte_t idx_a, idx_b, val_a, val_b;
  logic  swap_en;

  assign ksa_step     = (state == SQ_KSA);
  assign gen_swap     = (state == SQ_GEN);
  assign out_load     = (state == SQ_OUT);
  assign swap_en      = ksa_step || gen_swap;
  assign start_accept = start_req && (state == SQ_IDLE);
  assign din_accept   = din_req && (state == SQ_IDLE) && ready_q;

  // first swap partner: i itself while scheduling, i+1 while generating
  assign idx_a = gen_swap ? byte_t'(i_q + 1'b1) : i_q;
  assign val_a = s_q[idx_a];
  assign idx_b = ksa_step ? ksa_mix(j_q, val_a, key_byte) : gen_mix(j_q, val_a);
  assign val_b = s_q[idx_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      for (int n = 0; n < S_DEPTH; n++) s_q[n] <= byte_t'(n);
      i_q      <= '0;
      j_q      <= '0;
      t_q      <= '0;
      din_q    <= '0;
      dout_q   <= '0;
      kidx_q   <= '0;
      dvalid_q <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      if (swap_en) begin
        s_q[idx_a] <= val_b;
        s_q[idx_b] <= val_a;
        j_q        <= idx_b;
      end
      unique case (state)
        SQ_IDLE: begin
          if (start_accept) begin
            state    <= SQ_INIT;
            ready_q  <= 1'b0;
            dvalid_q <= 1'b0;
          end else if (din_accept) begin
            din_q    <= din_byte;
            dvalid_q <= 1'b0;
            state    <= SQ_GEN;
          end else if (dout_rd) begin
            dvalid_q <= 1'b0;
          end
        end
        SQ_INIT: begin
          for (int n = 0; n < S_DEPTH; n++) s_q[n] <= byte_t'(n);
          i_q    <= '0;
          j_q    <= '0;
          kidx_q <= '0;
          state  <= SQ_KSA;
        end
        SQ_KSA: begin
          i_q    <= byte_t'(i_q + 1'b1);
          kidx_q <= (kidx_q == key_lenm1) ? '0 : KI_W'(kidx_q + 1'b1);
          if (i_q == LAST_I) begin
            state   <= SQ_IDLE;
            ready_q <= 1'b1;
            j_q     <= '0;
          end
        end
        SQ_GEN: begin
          i_q   <= idx_a;
          t_q   <= out_index(val_a, val_b);
          state <= SQ_OUT;
        end
        SQ_OUT: begin
          dout_q   <= s_q[t_q] ^ din_q;
          dvalid_q <= 1'b1;
          state    <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign key_idx = kidx_q;
  assign dout    = dout_q;
  assign busy    = (state == SQ_INIT) || (state == SQ_KSA);
  assign dvalid  = dvalid_q;
  assign ready   = ready_q;

endmodule

// File: rtl/rc4p_engine.sv
module rc4p_engine
  import rc4p_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int KEY_DEPTH = 256
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata
);

  localparam int KI_W = $clog2(KEY_DEPTH);

  logic            start_wr, keylen_wr, key_wr, din_wr, dout_rd;
  logic [KI_W-1:0] bus_key_idx, sched_key_idx, key_lenm1;
  byte_t           wr_byte, key_byte, dout_byte;

  // named events for the checker
  logic sched_busy, stream_ready, out_valid;
  logic start_accept, din_accept, ksa_step, gen_swap, out_load;

  rc4p_apb_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_IDX_W(KI_W)
  ) u_apb (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .keylen_q(key_lenm1), .dout_q(dout_byte), .busy(sched_busy), .dvalid(out_valid),
    .ready(stream_ready), .start_wr(start_wr), .keylen_wr(keylen_wr), .key_wr(key_wr),
    .key_idx(bus_key_idx), .wr_byte(wr_byte), .din_wr(din_wr), .dout_rd(dout_rd),
    .prdata(prdata)
  );

  rc4p_key_store #(
    .KEY_DEPTH(KEY_DEPTH), .KI_W(KI_W)
  ) u_key (
    .clk(pclk), .rst_n(presetn), .lock(sched_busy), .len_wr(keylen_wr), .key_wr(key_wr),
    .wr_idx(bus_key_idx), .wr_byte(wr_byte), .rd_idx(sched_key_idx), .rd_byte(key_byte),
    .lenm1(key_lenm1)
  );

  rc4p_sbox_seq #(
    .KI_W(KI_W)
  ) u_seq (
    .clk(pclk), .rst_n(presetn), .start_req(start_wr), .din_req(din_wr), .din_byte(wr_byte),
    .dout_rd(dout_rd), .key_byte(key_byte), .key_lenm1(key_lenm1), .key_idx(sched_key_idx),
    .dout(dout_byte), .busy(sched_busy), .dvalid(out_valid), .ready(stream_ready),
    .start_accept(start_accept), .din_accept(din_accept), .ksa_step(ksa_step),
    .gen_swap(gen_swap), .out_load(out_load)
  );

endmodule

// File: rtl/rc4p_checker.sv
module rc4p_checker
  import rc4p_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [DATA_W-1:0] prdata,
  input logic              sched_busy,
  input logic              stream_ready,
  input logic              out_valid,
  input logic              start_accept,
  input logic              din_accept
);

  localparam int SCHED_CYC = S_DEPTH + 1;
  localparam int CNT_W     = $clog2(SCHED_CYC) + 1;

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)          busy_cnt <= '0;
    else if (start_accept) busy_cnt <= '0;
    else if (sched_busy)   busy_cnt <= CNT_W'(busy_cnt + 1'b1);
  end

  // R4: busy window is exactly one init cycle plus one step per entry
  p_sched_len_r4: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(sched_busy) |-> busy_cnt == CNT_W'(SCHED_CYC));

  // R4: an accepted start raises busy on the next cycle
  p_start_busy_r4: assert property (@(posedge pclk) disable iff (!presetn)
    start_accept |=> sched_busy);

  // R11: ready drops on start and is present when busy ends
  p_ready_drop_r11: assert property (@(posedge pclk) disable iff (!presetn)
    start_accept |=> !stream_ready);
  p_ready_rise_r11: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(sched_busy) |-> stream_ready);

  // R8: no data byte is taken during scheduling
  p_no_din_busy_r8: assert property (@(posedge pclk) disable iff (!presetn)
    sched_busy |-> !din_accept);

  // R6: valid rises three edges after the accepting edge
  p_valid_latency_r6: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(out_valid) |-> $past(din_accept, 3));

  // R10: read bus is quiet outside a read access
  p_rdata_quiet_r10: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && !pwrite) |-> prdata == '0);

endmodule

bind rc4p_engine rc4p_checker #(.DATA_W(DATA_W)) u_rc4p_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .prdata(prdata), .sched_busy(sched_busy), .stream_ready(stream_ready),
  .out_valid(out_valid), .start_accept(start_accept), .din_accept(din_accept)
);

// File: tb/test_rc4p_engine.sv
`timescale 1ns/1ps
module test_rc4p_engine;

  localparam logic [11:0] A_CTRL = 12'h000, A_LEN = 12'h004, A_STAT = 12'h008,
                          A_DIN = 12'h00C, A_DOUT = 12'h010, A_KEY = 12'h400;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;

  int nvec = 0, nbad = 0, cyc = 0;
  int ms [256];
  int mi, mj;
  logic [7:0] kb [256];

  always #2.5 pclk = ~pclk;
  always @(posedge pclk) cyc++;

  rc4p_engine i_rc4p_engine (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  // bench model: explicit temporary vector, then permutation
  task automatic model_schedule(input int len);
    int t [256];
    int j = 0, tmp;
    for (int n = 0; n < 256; n++) begin t[n] = kb[n % len]; ms[n] = n; end
    for (int n = 0; n < 256; n++) begin
      j = (j + ms[n] + t[n]) & 255;
      tmp = ms[n]; ms[n] = ms[j]; ms[j] = tmp;
    end
    mi = 0; mj = 0;
  endtask

  function automatic logic [7:0] model_next();
    int tmp;
    mi = (mi + 1) & 255;
    mj = (mj + ms[mi]) & 255;
    tmp = ms[mi]; ms[mi] = ms[mj]; ms[mj] = tmp;
    return 8'(ms[(ms[mi] + ms[mj]) & 255]);
  endfunction

  task automatic load_key(input int len);
    apb_wr(A_LEN, 32'(len - 1));
    for (int n = 0; n < len; n++) apb_wr(A_KEY + 12'(4 * n), {24'h0, kb[n]});
  endtask

  // start scheduling; optionally poke the block while busy
  task automatic schedule(input int len, input bit poke);
    logic [31:0] st;
    int t0, el;
    apb_wr(A_CTRL, 32'h1);
    t0 = cyc;
    apb_rd(A_STAT, st);
    chk("R4 busy after start", st, 32'h1);
    if (poke) begin
      apb_wr(A_CTRL, 32'h1);                 // R4 ignored restart
      apb_wr(A_KEY, 32'hFF);                 // R3 ignored key write
      apb_wr(A_LEN, 32'h7);                  // R2 ignored length write
      apb_wr(A_DIN, 32'h11);                 // R8 ignored data write
    end
    do apb_rd(A_STAT, st); while (st[0] && (cyc - t0) < 400);
    el = cyc - t0;
    chk("R4 busy duration in window", 32'((el >= 257) && (el <= 260)), 32'h1);
    chk("R11 ready after schedule", st, 32'h4);
    model_schedule(len);
  endtask

  task automatic crypt(input logic [7:0] d, input string req, output logic [7:0] got);
    logic [31:0] st, r;
    int tries = 0;
    apb_wr(A_DIN, {24'h0, d});
    do begin apb_rd(A_STAT, st); tries++; end while (!st[1] && tries < 8);
    apb_rd(A_DOUT, r);
    got = r[7:0];
    chk(req, r, {24'h0, d ^ model_next()});
  endtask

  logic [7:0] ptxt [9] = '{8'h50, 8'h6C, 8'h61, 8'h69, 8'h6E, 8'h74, 8'h65, 8'h78, 8'h74};
  logic [7:0] ctxt [9];

  initial begin : main
    logic [31:0] r;
    logic [7:0]  g;
    int len;
    void'($urandom(32'd20250611));
    repeat (4) @(negedge pclk);
    presetn = 1;

    // R1 / R2 / R10 reset and idle bus
    #1 chk("R10 idle prdata zero", prdata, 0);
    apb_rd(A_STAT, r); chk("R1 status after reset", r, 0);
    apb_rd(A_DOUT, r); chk("R1 dout after reset", r, 0);
    apb_rd(A_LEN, r);  chk("R1 keylen after reset", r, 0);
    apb_rd(12'h0FC, r); chk("R10 unmapped read zero", r, 0);
    apb_rd(A_DIN, r);   chk("R10 write-only reads zero", r, 0);

    // R8 data before any schedule
    apb_wr(A_DIN, 32'h5A);
    repeat (5) @(negedge pclk);
    apb_rd(A_STAT, r); chk("R8 no valid before schedule", r, 0);
    apb_rd(A_DOUT, r); chk("R8 dout unchanged", r, 0);

    // R2 length readback
    apb_wr(A_LEN, 32'h2A); apb_rd(A_LEN, r); chk("R2 keylen readback", r, 32'h2A);

    // R5 key "Key" with ignored pokes during busy (R3 R4 R8 R2)
    kb[0] = 8'h4B; kb[1] = 8'h65; kb[2] = 8'h79;
    load_key(3);
    schedule(3, 1'b1);
    apb_rd(A_LEN, r); chk("R2 keylen locked while busy", r, 32'h2);
    for (int n = 0; n < 9; n++) begin
      crypt(ptxt[n], "R5 R6 key Key stream", g);
      ctxt[n] = g;
      if (n == 0) begin
        chk("R5 known first cipher byte", {24'h0, g}, 32'hBB);
        apb_rd(A_STAT, r); chk("R7 valid cleared by dout read", r, 32'h4);
      end
    end

    // R12 decrypt by rescheduling the same key
    schedule(3, 1'b0);
    for (int n = 0; n < 9; n++) begin
      crypt(ctxt[n], "R12 decrypt", g);
      chk("R12 plaintext recovered", {24'h0, g}, {24'h0, ptxt[n]});
    end

    // R5 key "Wiki"
    kb[0] = 8'h57; kb[1] = 8'h69; kb[2] = 8'h6B; kb[3] = 8'h69;
    load_key(4);
    schedule(4, 1'b0);
    for (int n = 0; n < 6; n++) begin
      crypt(8'h00, "R5 key Wiki stream", g);
      if (n == 0) chk("R5 Wiki first keystream byte", {24'h0, g}, 32'h60);
    end

    // R5 R9 one-byte key, run past the index wrap
    kb[0] = 8'($urandom);
    load_key(1);
    schedule(1, 1'b0);
    for (int n = 0; n < 300; n++) crypt(8'($urandom), "R9 wrap past 255", g);

    // R5 full 256-byte key
    for (int n = 0; n < 256; n++) kb[n] = 8'($urandom);
    load_key(256);
    schedule(256, 1'b0);
    for (int n = 0; n < 20; n++) crypt(8'($urandom), "R5 256-byte key", g);

    // R5 random lengths, repeated-key fill
    for (int k = 0; k < 4; k++) begin
      len = 1 + int'($urandom % 256);
      for (int n = 0; n < len; n++) kb[n] = 8'($urandom);
      load_key(len);
      schedule(len, 1'b0);
      for (int n = 0; n < 16; n++) crypt(8'($urandom), "R5 random key length", g);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge pclk);
    nbad++;
    $display("FAIL watchdog expired got running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule